// File: doc/BRIEF.md
# I2S LSB-Justified Receive Unpacker

This block receives an I2S serial stream as a slave: the bit clock, word select and serial data all come from an external master. It oversamples them in the system clock domain and collects every channel slot, which is 32 bits wide. In each slot the sample sits in the least-significant bit positions. A complete slot is handed out as 16-bit half-words on a valid/ready read port.

When `pack_mode` is 0, a slot carries a 24-bit sample. It is handed out as two half-words. The first half-word holds the top eight sample bits, zero-filled above them. The second half-word holds the low sixteen bits. When `pack_mode` is 1, a slot carries a 16-bit sample padded to 32 bits. The padding is dropped, and a single half-word carries the sample.

The read port follows valid/ready rules:
- `rd_valid` means a half-word is waiting.
- A transfer happens on any cycle where `rd_valid` and `rd_ready` are both high.
- The consumer may hold `rd_ready` low for as long as it likes. While it does, the data and the channel tag stay frozen.

Only one slot is held at a time. A slot that completes while an earlier half-word is still unread is dropped, and `ovr` pulses.

Top module: `i2s_lsbj_rx`

## Requirements
- R1: Serial data is sampled on each rising edge of `i2s_ck`. If `i2s_ws` differs from its value at the previous rising edge, the bit taken on that edge is the final bit of the current slot, and the next rising edge starts a new slot. A slot is sent most-significant bit first, and it is tagged with the `i2s_ws` level held during the slot.
- R2: A slot is delivered only if exactly 32 rising edges were counted from the previous `i2s_ws` change up to and including the closing edge. Shorter slots are discarded, and so is the partial slot after reset.
- R3: With `pack_mode`=0, the first half-word of a slot is `{8'h00, slot[23:16]}`.
- R4: With `pack_mode`=0, the second half-word of the slot is `slot[15:0]`.
- R5: With `pack_mode`=1, a slot yields exactly one half-word, `slot[15:0]`, and `slot[31:16]` is discarded. `pack_mode` is sampled when the slot is taken into the holding stage.
- R6: `rd_valid` stays high until the last half-word of a slot is transferred. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_right` hold steady.
- R7: If a slot completes while any half-word is still unread, `ovr` is high for one cycle, the new slot is dropped, and the held data is unaffected.
- R8: If a slot completes in the same cycle that the last pending half-word is transferred, the slot is accepted and `ovr` stays low.
- R9: `rd_right` reports the `i2s_ws` level of the slot being presented: 1 for the right channel, 0 for the left.
- R10: After reset, `rd_valid` and `ovr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `i2s_ck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_ck | input | 1 | Serial bit clock from the master |
| i2s_ws | input | 1 | Word select from the master (0 left, 1 right) |
| i2s_sd | input | 1 | Serial data |
| pack_mode | input | 1 | 0: 24-bit sample in two half-words; 1: 16-bit sample in one |
| rd_valid | output | 1 | A half-word is waiting |
| rd_ready | input | 1 | Consumer accepts the half-word |
| rd_data | output | 16 | Half-word being presented |
| rd_right | output | 1 | Channel of the presented slot |
| ovr | output | 1 | One-cycle pulse when a slot is dropped |

## Verification
Two events can land in the same cycle: a slot closing on the serial side, and the consumer taking the last half-word of the previous slot. The bench first measures the latency from the closing bit-clock rising edge to `rd_valid` on an empty holding stage. It then sends the next slot with a half-word still pending and raises `rd_ready` exactly in the cycle the new slot lands. The handover passes if, in the following cycle, the new slot's data and channel are presented and no overrun pulse was seen. The opposite case, a slot closing while data still waits, must drop the new slot, pulse `ovr` and leave the old half-words readable.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  typedef enum logic {
    PK_SPLIT24 = 1'b0,
    PK_EXT16   = 1'b1
  } pk_mode_e;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser #(
  parameter int SLOT_W = 32,
  parameter int WIDE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ck_s,
  input  logic              ws_s,
  input  logic              sd_s,
  output logic              done,
  output logic [WIDE_W-1:0] word,
  output logic              side
);
  localparam int CW = $clog2(SLOT_W + 1);

  logic              ck_d;
  logic              ws_prev;
  logic [CW-1:0]     cnt;
  logic [WIDE_W-1:0] shreg;
  logic              rise;

  assign rise = ck_s & ~ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_d    <= 1'b0;
      ws_prev <= 1'b0;
      cnt     <= CW'(SLOT_W);
      shreg   <= '0;
      done    <= 1'b0;
      word    <= '0;
      side    <= 1'b0;
    end else begin
      done <= 1'b0;
      ck_d <= ck_s;
      if (rise) begin
        shreg   <= {shreg[WIDE_W-2:0], sd_s};
        ws_prev <= ws_s;
        if (ws_s != ws_prev) begin
          cnt <= '0;
          if (cnt == CW'(SLOT_W - 1)) begin
            done <= 1'b1;
            word <= {shreg[WIDE_W-2:0], sd_s};
            side <= ws_prev;
          end
        end else if (cnt != CW'(SLOT_W)) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_rx_unpack.sv
module i2s_rx_unpack
  import i2s_rx_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int WIDE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WIDE_W-1:0] word,
  input  logic              side,
  input  pk_mode_e          mode,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [HALF_W-1:0] rd_data,
  output logic              rd_right,
  output logic              ovr
);
  localparam int HI_BITS = WIDE_W - HALF_W;

  logic [1:0]        rem;
  logic [WIDE_W-1:0] hold;
  logic              free;

  assign rd_valid = (rem != 2'd0);
  assign free     = (rem == 2'd0) || (rem == 2'd1 && rd_ready);
  assign rd_data  = (rem == 2'd2) ? {{(HALF_W-HI_BITS){1'b0}}, hold[WIDE_W-1:HALF_W]}
                                  : hold[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= 2'd0;
      hold     <= '0;
      rd_right <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      ovr <= 1'b0;
      if (load && free) begin
        hold     <= word;
        rd_right <= side;
        rem      <= (mode == PK_EXT16) ? 2'd1 : 2'd2;
      end else begin
        if (load) ovr <= 1'b1;
        if (rd_valid && rd_ready) rem <= rem - 2'd1;
      end
    end
  end
endmodule

// File: rtl/i2s_lsbj_rx.sv
module i2s_lsbj_rx
  import i2s_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_W      = 32,
  parameter int HALF_W      = 16,
  parameter int WIDE_W      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i2s_ck,
  input  logic              i2s_ws,
  input  logic              i2s_sd,
  input  logic              pack_mode,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [HALF_W-1:0] rd_data,
  output logic              rd_right,
  output logic              ovr
);
  logic [2:0]        pins_s;
  logic              slot_done;
  logic [WIDE_W-1:0] slot_word;
  logic              slot_side;

  i2s_rx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({i2s_ck, i2s_ws, i2s_sd}),
    .q(pins_s)
  );

  i2s_rx_deser #(.SLOT_W(SLOT_W), .WIDE_W(WIDE_W)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .ck_s(pins_s[2]), .ws_s(pins_s[1]), .sd_s(pins_s[0]),
    .done(slot_done), .word(slot_word), .side(slot_side)
  );

  i2s_rx_unpack #(.HALF_W(HALF_W), .WIDE_W(WIDE_W)) u_unpack (
    .clk(clk), .rst_n(rst_n),
    .load(slot_done), .word(slot_word), .side(slot_side),
    .mode(pk_mode_e'(pack_mode)),
    .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_right(rd_right), .ovr(ovr)
  );
endmodule

// File: rtl/i2s_rx_chk.sv
module i2s_rx_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [HALF_W-1:0] rd_data,
  input logic              rd_right,
  input logic              ovr
);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R9
  side_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> $stable(rd_right));

  // R6
  drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> $past(rd_ready));

  // R7
  ovr_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> $past(rd_valid));

  // R7
  ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> !ovr);
endmodule

bind i2s_lsbj_rx i2s_rx_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_right(rd_right), .ovr(ovr)
);

// File: tb/i2s_lsbj_rx_bench.sv
module i2s_lsbj_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i2s_ck = 1'b0, i2s_ws = 1'b0, i2s_sd = 1'b0;
  logic        pack_mode = 1'b0;
  logic        rd_ready = 1'b0;
  logic        rd_valid, rd_right, ovr;
  logic [15:0] rd_data;

  int checks = 0, fails = 0, ovr_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2s_lsbj_rx u_i2s_lsbj_rx (
    .clk(clk), .rst_n(rst_n), .i2s_ck(i2s_ck), .i2s_ws(i2s_ws),
    .i2s_sd(i2s_sd), .pack_mode(pack_mode), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_right(rd_right), .ovr(ovr)
  );

  always @(negedge clk) if (rst_n && ovr) ovr_cnt++;

  // {pack_mode, slot, first half-word, second half-word}
  localparam logic [64:0] VEC [6] = '{
    {1'b0, 32'hA53478AE, 16'h0034, 16'h78AE},
    {1'b0, 32'h00FFFFFF, 16'h00FF, 16'hFFFF},
    {1'b1, 32'hDEAD76A3, 16'h76A3, 16'h0000},
    {1'b1, 32'h12340000, 16'h0000, 16'h0000},
    {1'b0, 32'hFF800001, 16'h0080, 16'h0001},
    {1'b1, 32'hFFFF8001, 16'h8001, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ck_bit(input logic w, input logic d);
    @(negedge clk);
    i2s_ck = 1'b0; i2s_ws = w; i2s_sd = d;
    repeat (4) @(negedge clk);
    i2s_ck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bits(input logic lvl, input logic [31:0] data, input int n, input logic nxt);
    for (int i = 0; i < n; i++) ck_bit((i == n - 1) ? nxt : lvl, data[n-1-i]);
  endtask

  task automatic read_half(output logic [15:0] d, output logic s);
    int t = 0;
    @(negedge clk);
    while (!rd_valid && t < 200) begin @(negedge clk); t++; end
    d = rd_data; s = rd_right;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  // sends a full slot with a hand-timed closing edge; ready_at < 0 measures latency
  task automatic send_timed(input logic lvl, input logic [31:0] data, input logic nxt,
                            input int ready_at, input logic [15:0] prev, output int lat);
    for (int i = 0; i < 31; i++) ck_bit(lvl, data[31-i]);
    @(negedge clk);
    i2s_ck = 1'b0; i2s_ws = nxt; i2s_sd = data[0];
    repeat (4) @(negedge clk);
    i2s_ck = 1'b1;
    lat = 0;
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      if (ready_at < 0 && lat == 0 && rd_valid) lat = j;
      if (j == ready_at) begin
        chk(rd_valid && rd_data == prev, "R8 pending half-word before handover", rd_data, prev);
        rd_ready = 1'b1;
      end else begin
        rd_ready = 1'b0;
      end
    end
  endtask

  initial begin
    logic [15:0] d;
    logic s;
    int lat, dummy, ov0;
    repeat (3) @(negedge clk);
    // R10
    chk(!rd_valid && !ovr, "R10 reset state", {rd_valid, ovr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rd_valid && !ovr, "R10 idle after reset", {rd_valid, ovr}, 0);

    // prime: WS change with no full slot before it (R2 partial slot dropped)
    ck_bit(1'b1, 1'b0);
    repeat (8) @(negedge clk);
    chk(!rd_valid, "R2 partial slot after reset", rd_valid, 0);

    for (int i = 0; i < 6; i++) begin
      logic lvl;
      logic [15:0] held;
      lvl = (i % 2 == 0);
      pack_mode = VEC[i][64];
      send_bits(lvl, VEC[i][63:32], 32, ~lvl);
      repeat (8) @(negedge clk);
      held = rd_data;
      repeat (6) @(negedge clk);
      chk(rd_valid && rd_data == held, "R6 stall holds data", rd_data, held);
      read_half(d, s);
      chk(d == VEC[i][31:16], VEC[i][64] ? "R5 single half-word" : "R3 upper half-word", d, VEC[i][31:16]);
      chk(s == lvl, "R9 channel tag", s, lvl);
      if (!VEC[i][64]) begin
        chk(rd_valid, "R6 valid held for second half", rd_valid, 1);
        read_half(d, s);
        chk(d == VEC[i][15:0], "R4 lower half-word", d, VEC[i][15:0]);
        chk(s == lvl, "R9 channel tag second half", s, lvl);
      end
      chk(!rd_valid, "R6 valid drops after last half", rd_valid, 0);
    end

    // R2: short slot (20 bits) is discarded
    send_bits(1'b1, 32'h000ABCDE, 20, 1'b0);
    repeat (10) @(negedge clk);
    chk(!rd_valid, "R2 short slot discarded", rd_valid, 0);

    // R1: slot framing picks the last 32 bits before the closing edge
    pack_mode = 1'b1;
    send_bits(1'b0, 32'h0000BEEF, 32, 1'b1);
    read_half(d, s);
    chk(d == 16'hBEEF && s == 1'b0, "R1 framing after short slot", {s, d}, {1'b0, 16'hBEEF});

    // R7: overrun drops second slot, keeps first
    pack_mode = 1'b0;
    ov0 = ovr_cnt;
    send_bits(1'b1, 32'h00ABCDEF, 32, 1'b0);
    send_bits(1'b0, 32'h00111111, 32, 1'b1);
    repeat (8) @(negedge clk);
    chk(ovr_cnt == ov0 + 1, "R7 overrun pulse count", ovr_cnt - ov0, 1);
    read_half(d, s);
    chk(d == 16'h00AB && s == 1'b1, "R7 held slot upper kept", {s, d}, {1'b1, 16'h00AB});
    read_half(d, s);
    chk(d == 16'hCDEF, "R7 held slot lower kept", d, 16'hCDEF);
    chk(!rd_valid, "R7 dropped slot not presented", rd_valid, 0);

    // R8: slot lands in the cycle the last pending half-word is taken
    pack_mode = 1'b1;
    ov0 = ovr_cnt;
    send_timed(1'b1, 32'h00005A5A, 1'b0, -1, 16'h0000, lat);
    chk(lat > 1, "R8 latency measured", lat, 2);
    send_timed(1'b0, 32'h0000C3C3, 1'b1, lat - 1, 16'h5A5A, dummy);
    chk(rd_valid && rd_data == 16'hC3C3 && rd_right == 1'b0, "R8 new slot accepted",
        {rd_right, rd_data}, {1'b0, 16'hC3C3});
    chk(ovr_cnt == ov0, "R8 no overrun on handover", ovr_cnt - ov0, 0);
    read_half(d, s);
    chk(!rd_valid, "R6 empty at end", rd_valid, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule